// File: doc/BRIEF.md
# Sensor Frame Timing Generator with Padding Lines

This block paces the readout of a raw image array one word per pixel clock and stamps the frame and line boundaries into the 10-bit output stream as embedded synchronization codes. A separate sync wire is not used. Each line is the same number of words: a four-word start sequence, one word per physical column, and a four-word end sequence. Rows come in this order: border rows, active rows, border rows, and then optional padding rows.

A frame-length input sets the total number of rows in a frame. Rows beyond the physical array carry a fixed filler in their pixel slots. Adding such rows lowers the frame rate, while the word rate inside each line stays the same. With the default parameters the array is 644 by 484, and the active window inside it is 640 by 480. The frame-length field spans a range more than ten times the default frame length. A timing-reset request restarts the frame from its first word. The enable input freezes the position. The pixel value at the input is passed through in the pixel slots, with the two values that could be mistaken for a preamble clipped.

Top module: `ftg_top`

## Requirements
- R1: A line is PW+8 words long, where PW = ACT_W+2*BORDER. Columns 0..3 carry 0x3FF, 0x000, 0x000 and a start code. Columns 4..PW+3 carry pixel slots. The last four columns carry 0x3FF, 0x000, 0x000 and an end code.
- R2: The code word is {1, blank, end, mark, 000000}. The blank bit is set on padding rows (row >= PH, where PH = ACT_H+2*BORDER). The end bit is set in the end sequence. The mark bit is set on the start code of row 0 and on the end code of the last row of the frame.
- R3: In array rows, the pixel slot carries pix_in, except that 0x000 is replaced by 0x001 and 0x3FF is replaced by 0x3FE.
- R4: Padding rows (PH up to the frame length minus 1) carry the fill word 0x040 in every pixel slot, and they keep the same line length as array rows.
- R5: frame_len is sampled only on the cycle that wraps from the last word of the last row to row 0. It is also sampled on a timing reset. A value applied mid-frame leaves the current frame's length unchanged.
- R6: A sampled frame length below PH is used as PH.
- R7: active_o is high exactly when BORDER <= row < BORDER+ACT_H and 4+BORDER <= col < 4+BORDER+ACT_W.
- R8: While en is low and no timing reset is requested, row_o and col_o hold their values.
- R9: A timing-reset request (tmr_req) sets row_o and col_o to 0 on the next cycle and loads the frame length. This takes priority over en.
- R10: After reset, row_o and col_o are 0 and the frame length is DEF_LEN (with the R6 floor applied).
- R11: When en is high, col_o counts up every cycle. When it wraps, row_o advances by one, and it returns to 0 after the last row of the frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| en | input | 1 | Advance the position when high |
| tmr_req | input | 1 | Restart the frame timing |
| frame_len | input | FL_W | Requested total rows per frame |
| pix_in | input | 10 | Raw pixel value for the current slot |
| row_o | output | FL_W | Current row within the frame |
| col_o | output | clog2(PW+8) | Current word within the line |
| active_o | output | 1 | Current word lies in the active window |
| dout | output | 10 | Output word: pixel, filler or sync |

## Verification
The bench builds the block with a 8 by 4 active window, a border of 1, an 8-bit length field and a default length of 8. This gives 18-word lines and 6 array rows, so a full frame fits in about 150 cycles. At that size the bench can reach several frames, the floor clamp (a request of 3 becomes 6), padding rows, a mid-frame length change that waits for the wrap, and timing resets. A sustained run of enable gaps also stays within reach.

// File: rtl/ftg_pkg.sv
package ftg_pkg;
  localparam int SYNC_LEN = 4;
  localparam logic [9:0] PRE_HI = 10'h3FF;
  localparam logic [9:0] PRE_LO = 10'h000;

  // code word: {1, blank, end, mark, 6'b0}
  function automatic logic [9:0] code_word(input logic blank, input logic is_end,
                                           input logic mark);
    return {1'b1, blank, is_end, mark, 6'b000000};
  endfunction

  function automatic logic [9:0] clip_pixel(input logic [9:0] p);
    if (p == 10'h000) return 10'h001;
    if (p == 10'h3FF) return 10'h3FE;
    return p;
  endfunction
endpackage

// File: rtl/ftg_line_ctr.sv
module ftg_line_ctr #(
  parameter int LINE_LEN = 652,
  parameter int CW       = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          tmr,
  output logic [CW-1:0] col,
  output logic          line_wrap
);
  logic at_last;
  assign at_last   = (col == CW'(LINE_LEN - 1));
  assign line_wrap = en && !tmr && at_last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         col <= '0;
    else if (tmr)       col <= '0;
    else if (line_wrap) col <= '0;
    else if (en)        col <= col + CW'(1);
  end
endmodule

// File: rtl/ftg_frame_ctr.sv
module ftg_frame_ctr #(
  parameter int RW      = 13,
  parameter int MIN_LEN = 484,
  parameter int DEF_LEN = 525
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tmr,
  input  logic          line_wrap,
  input  logic [RW-1:0] len_req,
  output logic [RW-1:0] row,
  output logic [RW-1:0] len_q,
  output logic          frame_wrap
);
  localparam int DEF_EFF = (DEF_LEN < MIN_LEN) ? MIN_LEN : DEF_LEN;

  logic [RW-1:0] len_eff;
  assign len_eff    = (len_req < RW'(MIN_LEN)) ? RW'(MIN_LEN) : len_req;
  assign frame_wrap = line_wrap && (row == len_q - RW'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      row   <= '0;
      len_q <= RW'(DEF_EFF);
    end else if (tmr || frame_wrap) begin
      row   <= '0;
      len_q <= len_eff;
    end else if (line_wrap) begin
      row   <= row + RW'(1);
    end
  end
endmodule

// File: rtl/ftg_word_mux.sv
module ftg_word_mux
  import ftg_pkg::*;
#(
  parameter int RW     = 13,
  parameter int CW     = 10,
  parameter int ACT_W  = 640,
  parameter int ACT_H  = 480,
  parameter int BORDER = 2,
  parameter logic [9:0] BLANK_FILL = 10'h040
) (
  input  logic [RW-1:0] row,
  input  logic [CW-1:0] col,
  input  logic [RW-1:0] len_q,
  input  logic [9:0]    pix_in,
  output logic [9:0]    dout,
  output logic          active
);
  localparam int PW      = ACT_W + 2 * BORDER;
  localparam int PH      = ACT_H + 2 * BORDER;
  localparam int PIX_END = SYNC_LEN + PW;

  logic          blank_row, first_row, last_row, in_head, in_tail, mark;
  logic [CW-1:0] tail_off;
  logic [1:0]    idx;

  assign blank_row = (row >= RW'(PH));
  assign first_row = (row == '0);
  assign last_row  = (row == len_q - RW'(1));
  assign in_head   = (col < CW'(SYNC_LEN));
  assign in_tail   = (col >= CW'(PIX_END));
  assign tail_off  = col - CW'(PIX_END);
  assign idx       = in_head ? col[1:0] : tail_off[1:0];
  assign mark      = in_tail ? last_row : first_row;

  always_comb begin
    if (in_head || in_tail) begin
      case (idx)
        2'd0:    dout = PRE_HI;
        2'd3:    dout = code_word(blank_row, in_tail, mark);
        default: dout = PRE_LO;
      endcase
    end else if (blank_row) begin
      dout = BLANK_FILL;
    end else begin
      dout = clip_pixel(pix_in);
    end
  end

  assign active = (row >= RW'(BORDER)) && (row < RW'(BORDER + ACT_H)) &&
                  (col >= CW'(SYNC_LEN + BORDER)) &&
                  (col < CW'(SYNC_LEN + BORDER + ACT_W));
endmodule

// File: rtl/ftg_top.sv
module ftg_top #(
  parameter int ACT_W   = 640,
  parameter int ACT_H   = 480,
  parameter int BORDER  = 2,
  parameter int FL_W    = 13,
  parameter int DEF_LEN = 525,
  parameter logic [9:0] BLANK_FILL = 10'h040
) (
  input  logic                                    clk,
  input  logic                                    rst_n,
  input  logic                                    en,
  input  logic                                    tmr_req,
  input  logic [FL_W-1:0]                         frame_len,
  input  logic [9:0]                              pix_in,
  output logic [FL_W-1:0]                         row_o,
  output logic [$clog2(ACT_W+2*BORDER+8)-1:0]     col_o,
  output logic                                    active_o,
  output logic [9:0]                              dout
);
  localparam int PW = ACT_W + 2 * BORDER;
  localparam int PH = ACT_H + 2 * BORDER;
  localparam int LL = PW + 2 * ftg_pkg::SYNC_LEN;
  localparam int CW = $clog2(LL);

  logic            line_wrap, frame_wrap;
  logic [FL_W-1:0] len_q;

  ftg_line_ctr #(.LINE_LEN(LL), .CW(CW)) u_line (
    .clk(clk), .rst_n(rst_n), .en(en), .tmr(tmr_req),
    .col(col_o), .line_wrap(line_wrap)
  );

  ftg_frame_ctr #(.RW(FL_W), .MIN_LEN(PH), .DEF_LEN(DEF_LEN)) u_frame (
    .clk(clk), .rst_n(rst_n), .tmr(tmr_req), .line_wrap(line_wrap),
    .len_req(frame_len), .row(row_o), .len_q(len_q), .frame_wrap(frame_wrap)
  );

  ftg_word_mux #(.RW(FL_W), .CW(CW), .ACT_W(ACT_W), .ACT_H(ACT_H),
                 .BORDER(BORDER), .BLANK_FILL(BLANK_FILL)) u_mux (
    .row(row_o), .col(col_o), .len_q(len_q), .pix_in(pix_in),
    .dout(dout), .active(active_o)
  );
endmodule

// File: rtl/ftg_chk.sv
module ftg_chk #(
  parameter int FL_W = 13,
  parameter int CW   = 10,
  parameter int PW   = 644,
  parameter int PH   = 484,
  parameter int AH   = 480,
  parameter int B    = 2
) (
  input logic            clk,
  input logic            rst_n,
  input logic            en,
  input logic            tmr_req,
  input logic [FL_W-1:0] row_o,
  input logic [CW-1:0]   col_o,
  input logic            active_o,
  input logic [9:0]      dout,
  input logic [FL_W-1:0] len_q,
  input logic            line_wrap,
  input logic            frame_wrap
);
  AST_COL_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    line_wrap |=> (col_o == '0)); // R1
  AST_FRAME_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    frame_wrap |=> (row_o == '0)); // R11
  AST_PIX_CLIP: assert property (@(posedge clk) disable iff (!rst_n)
    (col_o >= CW'(4) && col_o < CW'(4 + PW)) |-> (dout != 10'h000 && dout != 10'h3FF)); // R3
  AST_ROW_IN_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    row_o < len_q); // R5
  AST_LEN_AT_START: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(len_q) |-> (row_o == '0 && col_o == '0)); // R5
  AST_LEN_FLOOR: assert property (@(posedge clk) disable iff (!rst_n)
    len_q >= FL_W'(PH)); // R6
  AST_ACTIVE_ROWS: assert property (@(posedge clk) disable iff (!rst_n)
    active_o |-> (row_o >= FL_W'(B) && row_o < FL_W'(B + AH))); // R7
  AST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && !tmr_req) |=> ($stable(row_o) && $stable(col_o))); // R8
  AST_TMR_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    tmr_req |=> (row_o == '0 && col_o == '0)); // R9
endmodule

bind ftg_top ftg_chk #(.FL_W(FL_W), .CW(CW), .PW(PW), .PH(PH), .AH(ACT_H), .B(BORDER)) u_chk (
  .clk(clk), .rst_n(rst_n), .en(en), .tmr_req(tmr_req), .row_o(row_o),
  .col_o(col_o), .active_o(active_o), .dout(dout), .len_q(len_q),
  .line_wrap(line_wrap), .frame_wrap(frame_wrap)
);

// File: tb/tb_ftg_top.sv
module tb_ftg_top;
  localparam int AW = 8, AH = 4, B = 1, FLW = 8, DEF = 8;
  localparam int PW = AW + 2 * B, PH = AH + 2 * B, LL = PW + 8;
  localparam int CWB = $clog2(LL);

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_n, en, tmr_req, active_o;
  logic [FLW-1:0] frame_len, row_o;
  logic [9:0] pix_in, dout;
  logic [CWB-1:0] col_o;

  ftg_top #(.ACT_W(AW), .ACT_H(AH), .BORDER(B), .FL_W(FLW), .DEF_LEN(DEF)) dut (
    .clk(clk), .rst_n(rst_n), .en(en), .tmr_req(tmr_req), .frame_len(frame_len),
    .pix_in(pix_in), .row_o(row_o), .col_o(col_o), .active_o(active_o), .dout(dout)
  );

  typedef struct { int row; int col; int word; bit act; string tag; } exp_t;
  exp_t q[$];
  int n_chk = 0, n_fail = 0, k = 0;
  int m_row, m_col, m_len;
  bit p_en = 0, p_tmr = 0;
  int p_fl = DEF;
  string cur_tag = "R10";

  function automatic int floor_len(int v); return (v < PH) ? PH : v; endfunction

  function automatic int want_word(int r, int c, int p, int len);
    int kk, cw;
    if (c < 4 || c >= LL - 4) begin
      kk = (c < 4) ? c : c - (LL - 4);
      if (kk == 0) return 'h3FF;
      if (kk < 3) return 0;
      cw = 'h200;
      if (r >= PH) cw += 'h100;
      if (c >= 4) cw += 'h80;
      if ((c < 4 && r == 0) || (c >= 4 && r == len - 1)) cw += 'h40;
      return cw;
    end
    if (r >= PH) return 'h040;
    if (p == 0) return 1;
    if (p == 'h3FF) return 'h3FE;
    return p;
  endfunction

  function automatic string slot_tag(int r, int c);
    if (c < 4 || c >= LL - 4) return ((c % 4 == 3) || (c == LL - 1)) ? "R2" : "R1";
    return (r >= PH) ? "R4" : "R3";
  endfunction

  task automatic check(string tag, int act, int want);
    n_chk++;
    if (act != want) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, want);
    end
  endtask

  // model advance using the inputs of the previous cycle
  task automatic advance();
    if (p_tmr) begin
      m_row = 0; m_col = 0; m_len = floor_len(p_fl);
    end else if (p_en) begin
      m_col++;
      if (m_col == LL) begin
        m_col = 0; m_row++;
        if (m_row == m_len) begin m_row = 0; m_len = floor_len(p_fl); end
      end
    end
  endtask

  task automatic drive(bit e, bit t, int fl, int n);
    for (int i = 0; i < n; i++) begin
      exp_t x;
      int p;
      @(posedge clk);
      advance();
      #1;
      k++;
      p = (k % 5 == 0) ? 0 : (k % 5 == 1) ? 'h3FF : ((k * 37) & 'h3FF);
      en = e; tmr_req = t; frame_len = FLW'(fl); pix_in = 10'(p);
      p_en = e; p_tmr = t; p_fl = fl;
      x.row = m_row; x.col = m_col; x.word = want_word(m_row, m_col, p, m_len);
      x.act = (m_row >= B && m_row < B + AH && m_col >= 4 + B && m_col < 4 + B + AW);
      x.tag = cur_tag;
      q.push_back(x);
    end
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (rst_n && q.size() > 0) begin
      exp_t x;
      x = q.pop_front();
      check({x.tag, "/R11 row"}, int'(row_o), x.row);
      check({x.tag, "/R11 col"}, int'(col_o), x.col);
      check({x.tag, "/", slot_tag(x.row, x.col), " dout"}, int'(dout), x.word);
      check({x.tag, "/R7 active"}, int'(active_o), int'(x.act));
    end
  end

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    #(8 * 100000);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=running expected=done");
    finish_run();
  end

  initial begin
    rst_n = 0; en = 0; tmr_req = 0; frame_len = FLW'(DEF); pix_in = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R10 row", int'(row_o), 0);
    check("R10 col", int'(col_o), 0);
    check("R10 dout", int'(dout), 'h3FF);
    m_row = 0; m_col = 0; m_len = floor_len(DEF);
    @(posedge clk); #1 rst_n = 1;
    cur_tag = "R10"; drive(1, 0, 8, LL * 8);
    cur_tag = "R6";  drive(1, 0, 3, LL * 8 + LL * 12);
    cur_tag = "R5";  drive(1, 0, 3, LL * 2 + 5);
    drive(1, 0, 12, LL * 4 + LL * 12 + LL * 3);
    cur_tag = "R4";  drive(1, 0, 9, LL * 20);
    cur_tag = "R8";
    for (int i = 0; i < 240; i++) drive(i % 3 != 0, 0, 9, 1);
    cur_tag = "R9";  drive(1, 0, 7, 40);
    drive(0, 1, 7, 1);
    drive(1, 0, 7, LL * 7 + 10);
    drive(1, 1, 7, 1);
    drive(1, 0, 7, LL * 3);
    @(posedge clk); advance(); #1 en = 0; p_en = 0;
    repeat (3) @(posedge clk);
    finish_run();
  end
endmodule